// File: doc/BRIEF.md
# Serial Register Bus Master

This engine sits between a simple request port and a remote register bank reached over a slow serial link. The link has four wires: a frame select, a serial clock, a line carrying bits toward the remote bank and a line returning bits from it. The remote side also raises a ready flag when it can take a frame, and the engine owns a reset output that it can pulse to recover the remote side.

When a request is accepted, the engine first waits for ready. Each wait has a cycle budget. If the budget runs out, the engine pulses the reset output and waits again, and it makes a fixed number of attempts in all. Once ready is seen, it raises select and shifts the frame out most-significant bit first. A write sends the data word, then the register address, then a direction bit of one. A read sends the address, then a direction bit of zero, then gives 32 clock pulses and collects the returned word. Select falls, and the outgoing line is cleared, just before the direction bit. The half-period of the serial clock is a parameter counted in system clock cycles.

Top module: `serbus_master`

## Requirements
- R1: After reset, select, serial clock, outgoing data and the remote reset output are all low, `req_ready` is high and `rsp_done` is low.
- R2: While the engine waits for ready or pulses reset, select, serial clock and outgoing data stay low.
- R3: Select rises only in the cycle after the ready input was sampled high during a wait, and it stays low for any request whose waits all fail.
- R4: Each wait lasts `READY_TIMEOUT` cycles without ready. A failed wait that is not the last one is followed by a reset pulse exactly `RESET_CYC` cycles wide, after which the next wait starts. No more than `MAX_TRIES` waits are made.
- R5: When all `MAX_TRIES` waits fail, the engine ends the request with `rsp_done` and `rsp_error` high and sends no clock edges.
- R6: A write frame has 36 rising clock edges. The outgoing line carries, at those edges, the 32 data bits MSB first, then the 3 address bits MSB first, then the direction value 1.
- R7: A read frame has 36 rising clock edges: the 3 address bits MSB first, the direction value 0, then 32 pulses. The return line is sampled at the end of each pulse's high phase, and the samples are assembled MSB first into `rsp_rdata`.
- R8: For each bit, the serial clock is low for `HALF_CYC` cycles and then high for at least `HALF_CYC` cycles. The outgoing line never changes on a rising clock edge.
- R9: Select is high at every address and data edge. Select is low, and the outgoing line is zero, in the cycle before the direction bit is driven. The outgoing line is zero at every read-return pulse.
- R10: `req_ready` is high only while idle. `rsp_done` is a single-cycle pulse at the end of each request. `rsp_error` is low after a successful frame, and `req_ready` returns the cycle after `rsp_done`.
- R11: If ready arrives during the second wait, the request completes normally after exactly one reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Remote register address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle end-of-request pulse |
| rsp_error | output | 1 | Ready never arrived (valid with rsp_done) |
| rsp_rdata | output | DATA_W | Read word (valid with rsp_done on reads) |
| link_sel | output | 1 | Frame select |
| link_sclk | output | 1 | Serial clock |
| link_mosi | output | 1 | Data toward the remote bank |
| link_miso | input | 1 | Data from the remote bank |
| link_ready | input | 1 | Remote side ready flag |
| link_reset | output | 1 | Reset pulse to the remote side |

## Verification
A corrupted shift register or bit counter shows up during the frame itself. It appears as a wrong bit at a rising edge or a frame that is not 36 edges long, and the mismatch is caught at the `rsp_done` of that request. A fault in the wait/retry logic shows up as a reset pulse of the wrong width, a gap between pulses that differs from the timeout, a missing or extra pulse, or select rising without ready. Each of these can be seen within one timeout window. A phase or half-period fault shows up as an uneven clock run or as data moving on a rising edge, which is visible at the very next clock edge of the link.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_GUARD, ST_TX, ST_TURN, ST_DIR, ST_RX, ST_DONE
  } sbm_state_e;

  typedef enum logic [1:0] {
    GD_IDLE, GD_POLL, GD_RST
  } sbm_guard_e;
endpackage

// File: rtl/sbm_halfclk.sv
module sbm_halfclk #(
  parameter int HALF_CYC = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt == CW'(HALF_CYC - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == CW'(HALF_CYC - 1));
endmodule

// File: rtl/sbm_ready_guard.sv
module sbm_ready_guard
  import sbm_pkg::*;
#(
  parameter int TIMEOUT = 2000,
  parameter int TRIES   = 3,
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic link_ready,
  output logic granted,
  output logic failed,
  output logic link_reset
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam int NW = $clog2(TRIES + 1);

  sbm_guard_e    gs;
  logic [TW-1:0] tcnt;
  logic [RW-1:0] rcnt;
  logic [NW-1:0] tries;
  logic          expired;
  logic          last_try;

  assign expired  = (tcnt == TW'(TIMEOUT - 1));
  assign last_try = (tries == NW'(TRIES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      gs    <= GD_IDLE;
      tcnt  <= '0;
      rcnt  <= '0;
      tries <= '0;
    end else begin
      case (gs)
        GD_IDLE: if (start) begin
          gs    <= GD_POLL;
          tcnt  <= '0;
          tries <= '0;
        end
        GD_POLL: begin
          if (link_ready) gs <= GD_IDLE;
          else if (expired) begin
            if (last_try) gs <= GD_IDLE;
            else begin
              gs    <= GD_RST;
              rcnt  <= '0;
              tries <= tries + 1'b1;
            end
          end else tcnt <= tcnt + 1'b1;
        end
        GD_RST: begin
          if (rcnt == RW'(RST_CYC - 1)) begin
            gs   <= GD_POLL;
            tcnt <= '0;
          end else rcnt <= rcnt + 1'b1;
        end
        default: gs <= GD_IDLE;
      endcase
    end
  end

  assign granted    = (gs == GD_POLL) && link_ready;
  assign failed     = (gs == GD_POLL) && !link_ready && expired && last_try;
  assign link_reset = (gs == GD_RST);

  assert_tries_bound_R4: assert property (@(posedge clk) disable iff (rst)
    tries < NW'(TRIES));

  assert_pulse_then_poll_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(link_reset) |-> (gs == GD_POLL) && (tcnt == '0));
endmodule

// File: rtl/serbus_master.sv
module serbus_master
  import sbm_pkg::*;
#(
  parameter int ADDR_W        = 3,
  parameter int DATA_W        = 32,
  parameter int HALF_CYC      = 250,
  parameter int READY_TIMEOUT = 2000,
  parameter int MAX_TRIES     = 3,
  parameter int RESET_CYC     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              link_sel,
  output logic              link_sclk,
  output logic              link_mosi,
  input  logic              link_miso,
  input  logic              link_ready,
  output logic              link_reset
);
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int BW      = $clog2(FRAME_W + 1);
  localparam int RXW     = $clog2(DATA_W + 1);

  sbm_state_e         state;
  logic [FRAME_W-1:0] tx_sr;
  logic [BW-1:0]      bits_left;
  logic [DATA_W-1:0]  rx_sr;
  logic [RXW-1:0]     rx_cnt;
  logic               ph;
  logic               wr_q;
  logic               sel_q, sclk_q, mosi_q, err_q;
  logic               accept, tick, granted, failed, shift_en;

  assign accept   = (state == ST_IDLE) && req_valid;
  assign shift_en = (state == ST_TX) || (state == ST_DIR) || (state == ST_RX);

  sbm_halfclk #(.HALF_CYC(HALF_CYC)) u_half (
    .clk(clk), .rst(rst), .en(shift_en), .tick(tick)
  );

  sbm_ready_guard #(
    .TIMEOUT(READY_TIMEOUT), .TRIES(MAX_TRIES), .RST_CYC(RESET_CYC)
  ) u_guard (
    .clk(clk), .rst(rst), .start(accept), .link_ready(link_ready),
    .granted(granted), .failed(failed), .link_reset(link_reset)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tx_sr     <= '0;
      bits_left <= '0;
      rx_sr     <= '0;
      rx_cnt    <= '0;
      ph        <= 1'b0;
      wr_q      <= 1'b0;
      sel_q     <= 1'b0;
      sclk_q    <= 1'b0;
      mosi_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          sel_q  <= 1'b0;
          sclk_q <= 1'b0;
          mosi_q <= 1'b0;
          if (req_valid) begin
            wr_q      <= req_write;
            tx_sr     <= req_write ? {req_wdata, req_addr} : {req_addr, {DATA_W{1'b0}}};
            bits_left <= req_write ? BW'(FRAME_W) : BW'(ADDR_W);
            err_q     <= 1'b0;
            state     <= ST_GUARD;
          end
        end
        ST_GUARD: begin
          if (granted) begin
            sel_q  <= 1'b1;
            sclk_q <= 1'b0;
            mosi_q <= tx_sr[FRAME_W-1];
            ph     <= 1'b0;
            state  <= ST_TX;
          end else if (failed) begin
            err_q <= 1'b1;
            state <= ST_DONE;
          end
        end
        ST_TX: if (tick) begin
          if (!ph) begin
            ph     <= 1'b1;
            sclk_q <= 1'b1;
          end else if (bits_left > BW'(1)) begin
            ph        <= 1'b0;
            sclk_q    <= 1'b0;
            tx_sr     <= {tx_sr[FRAME_W-2:0], 1'b0};
            mosi_q    <= tx_sr[FRAME_W-2];
            bits_left <= bits_left - 1'b1;
          end else begin
            sel_q  <= 1'b0;
            mosi_q <= 1'b0;
            state  <= ST_TURN;
          end
        end
        ST_TURN: begin
          mosi_q <= wr_q;
          sclk_q <= 1'b0;
          ph     <= 1'b0;
          state  <= ST_DIR;
        end
        ST_DIR: if (tick) begin
          if (!ph) begin
            ph     <= 1'b1;
            sclk_q <= 1'b1;
          end else begin
            mosi_q <= 1'b0;
            if (wr_q) state <= ST_DONE;
            else begin
              ph     <= 1'b0;
              sclk_q <= 1'b0;
              rx_cnt <= '0;
              state  <= ST_RX;
            end
          end
        end
        ST_RX: if (tick) begin
          if (!ph) begin
            ph     <= 1'b1;
            sclk_q <= 1'b1;
          end else begin
            rx_sr <= {rx_sr[DATA_W-2:0], link_miso};
            if (rx_cnt == RXW'(DATA_W - 1)) state <= ST_DONE;
            else begin
              rx_cnt <= rx_cnt + 1'b1;
              ph     <= 1'b0;
              sclk_q <= 1'b0;
            end
          end
        end
        ST_DONE: begin
          sel_q  <= 1'b0;
          sclk_q <= 1'b0;
          mosi_q <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_done  = (state == ST_DONE);
  assign rsp_error = err_q;
  assign rsp_rdata = rx_sr;
  assign link_sel  = sel_q;
  assign link_sclk = sclk_q;
  assign link_mosi = mosi_q;

  assert_sel_after_ready_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(link_sel) |-> $past(link_ready));

  assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
    link_reset |-> !link_sel && !link_sclk && !link_mosi);

  assert_mosi_steady_at_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(link_sclk) |-> $stable(link_mosi));

  assert_turnaround_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(link_sel) |-> !link_mosi && link_sclk);

  assert_done_to_idle_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> req_ready && !rsp_done);
endmodule

// File: tb/test_serbus_master.sv
module test_serbus_master;
  localparam int HALF = 3;
  localparam int TO   = 12;
  localparam int RSTC = 4;
  localparam int TRY  = 3;

  typedef struct {
    bit          w;
    int          n;
    logic [67:0] mosi;
    logic [67:0] sel;
    logic        err;
    logic [31:0] rdata;
    int          n_resets;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_done, rsp_error;
  logic [31:0] rsp_rdata;
  logic link_sel, link_sclk, link_mosi, link_reset, link_ready;
  logic link_miso = 1'b0;

  int rdy_mode = 0;
  logic [31:0] cur_rword = '0;
  exp_t q[$];
  int checks = 0, errors = 0;

  // monitor state
  int rst_count = 0;
  int ncap = 0, lo_run = 0, hi_run = 0, rlen = 0, gap = 0, nfall = 0;
  logic [67:0] cap_mosi = '0, cap_sel = '0;
  bit tbad = 0, rdybad = 0;
  logic prev_s = 0, prev_r = 0;

  assign link_ready = (rdy_mode == 0) || (rdy_mode == 1 && rst_count > 0);

  always #2.5 clk = ~clk;

  serbus_master #(
    .ADDR_W(3), .DATA_W(32), .HALF_CYC(HALF), .READY_TIMEOUT(TO),
    .MAX_TRIES(TRY), .RESET_CYC(RSTC)
  ) i_serbus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .link_sel(link_sel), .link_sclk(link_sclk), .link_mosi(link_mosi),
    .link_miso(link_miso), .link_ready(link_ready), .link_reset(link_reset)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: builds expected item, pushes it, then issues the request
  task automatic send(input bit w, input logic [2:0] a, input logic [31:0] d,
                      input logic [31:0] rword, input int mode);
    exp_t e;
    e.w = w; e.mosi = '0; e.sel = '0; e.rdata = rword;
    e.err = (mode == 2);
    e.n_resets = (mode == 0) ? 0 : (mode == 1) ? 1 : TRY - 1;
    if (mode == 2) e.n = 0;
    else if (w) begin
      e.n = 36;
      for (int i = 0; i < 32; i++) begin e.mosi[i] = d[31-i]; e.sel[i] = 1'b1; end
      for (int i = 0; i < 3; i++) begin e.mosi[32+i] = a[2-i]; e.sel[32+i] = 1'b1; end
      e.mosi[35] = 1'b1;
    end else begin
      e.n = 36;
      for (int i = 0; i < 3; i++) begin e.mosi[i] = a[2-i]; e.sel[i] = 1'b1; end
    end
    @(negedge clk);
    rdy_mode  = mode;
    cur_rword = rword;
    q.push_back(e);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (link_sclk && !prev_s) begin
        if (ncap > 0 && lo_run != HALF) tbad = 1;
        if (ncap < 68) begin cap_mosi[ncap] = link_mosi; cap_sel[ncap] = link_sel; end
        if (req_ready) rdybad = 1;
        if (ncap >= 4 && q.size() > 0 && !q[0].w && ncap < 36)
          link_miso = cur_rword[31 - (ncap - 4)];
        ncap++;
        hi_run = 1;
      end else if (link_sclk) hi_run++;
      if (!link_sclk && prev_s) begin
        if (hi_run < HALF) tbad = 1;
        lo_run = 1;
      end else if (!link_sclk) lo_run++;

      if (link_reset && !prev_r) begin
        rst_count++;
        chk(!link_sel && !link_sclk && !link_mosi, "R2",
            $sformatf("lines sel/sclk/mosi=%b%b%b exp 000 during reset", link_sel, link_sclk, link_mosi));
        if (nfall > 0) chk(gap == TO, "R4", $sformatf("wait between pulses %0d exp %0d", gap, TO));
        rlen = 1;
      end else if (link_reset) rlen++;
      if (!link_reset && prev_r) begin
        chk(rlen == RSTC, "R4", $sformatf("reset width %0d exp %0d", rlen, RSTC));
        nfall++;
        gap = 1;
      end else if (!link_reset) gap++;
      prev_s = link_sclk;
      prev_r = link_reset;

      if (rsp_done) begin
        if (q.size() == 0) chk(0, "R10", "unexpected done, exp none");
        else begin
          exp_t e;
          logic [67:0] m;
          e = q.pop_front();
          m = '0;
          for (int i = 0; i < e.n; i++) m[i] = 1'b1;
          chk(rsp_error == e.err, e.err ? "R5" : "R10",
              $sformatf("error %b exp %b", rsp_error, e.err));
          chk(ncap == e.n, e.err ? "R5" : "R6",
              $sformatf("edges %0d exp %0d", ncap, e.n));
          chk(rst_count == e.n_resets, (e.n_resets == 1) ? "R11" : "R4",
              $sformatf("reset pulses %0d exp %0d", rst_count, e.n_resets));
          if (e.n > 0) begin
            chk((cap_mosi & m) == e.mosi, e.w ? "R6" : "R7",
                $sformatf("bits %h exp %h", cap_mosi & m, e.mosi));
            chk((cap_sel & m) == e.sel, "R9",
                $sformatf("select %h exp %h", cap_sel & m, e.sel));
            chk(!tbad, "R8", "clock runs uneven, exp HALF low/high");
            chk(!rdybad, "R10", "req_ready 1 during frame, exp 0");
            if (!e.w) chk(rsp_rdata == e.rdata, "R7",
                          $sformatf("rdata %h exp %h", rsp_rdata, e.rdata));
          end else begin
            chk(cap_sel == '0, "R3", $sformatf("select seen %h exp 0", cap_sel));
          end
        end
        ncap = 0; tbad = 0; rdybad = 0; cap_mosi = '0; cap_sel = '0;
        rst_count = 0; nfall = 0; link_miso = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WDOG", "run hung, exp completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!link_sel && !link_sclk && !link_mosi, "R1",
        $sformatf("link %b%b%b exp 000", link_sel, link_sclk, link_mosi));
    chk(!link_reset, "R1", $sformatf("link_reset %b exp 0", link_reset));
    chk(req_ready, "R1", $sformatf("req_ready %b exp 1", req_ready));
    chk(!rsp_done, "R1", $sformatf("rsp_done %b exp 0", rsp_done));

    send(1'b1, 3'd5, 32'hA5C3_0F96, 32'h0, 0);          // R6 mixed pattern
    send(1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0, 0);          // R6 all-ones data, zero address
    send(1'b0, 3'd7, 32'h0, 32'h8000_0001, 0);          // R7 end bits
    send(1'b0, 3'd2, 32'h0, 32'h1234_5678, 0);          // R7 mixed
    send(1'b1, 3'd3, 32'h0000_0001, 32'h0, 1);          // R11 second attempt
    send(1'b0, 3'd6, 32'h0, 32'hDEAD_BEEF, 2);          // R5 all attempts fail
    send(1'b0, 3'd1, 32'h0, 32'hFFFF_FFFE, 0);          // R10 recovery after error
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_done, "R10",
        $sformatf("idle ready=%b done=%b exp 1,0", req_ready, rsp_done));
    summary();
  end
endmodule